// File: doc/BRIEF.md
# Multi-Channel SAR ADC Serial Reader

This block is a serial master that runs one conversion on a small successive-approximation converter. The converter has 1, 2, 4 or 8 analog inputs and a resolution of 10, 12 or 13 bits. The converter variant is fixed at build time by two parameters, the input count and the resolution. At run time the user supplies a channel index and a single-ended/differential choice, then pulses a start request.

For converters with more than one input, the block builds a one-byte command and sends it most-significant bit first. It then clocks in two reply bytes. Single-input converters have no data-in pin, so the block only reads from them. Once the last bit is in, the block releases chip-select and pulls the conversion result out of the 16 received bits. The result is presented zero-extended, or sign-extended for the signed 13-bit variant, together with a one-cycle valid strobe.

The serial clock is idle low and the link uses SPI mode 0. Each clock half-period lasts `HALF_DIV` system clocks.

Top module: `sar_spi_reader`

## Requirements
- R1: While reset is applied and afterwards until a start request is accepted, `cs_n_o` is 1 and `sclk_o`, `mosi_o` and `valid_o` are 0.
- R2: Chip-select stays low for one whole transaction of N serial clock pulses. N is 24 for multi-input variants and 16 for single-input variants. Chip-select goes low in the cycle after the start request is accepted. The low time is exactly (2N+1)·HALF_DIV system clocks. The serial clock is idle low, MOSI changes only on its falling edges, and MISO is sampled on its rising edges.
- R3: For two-input variants, the command byte has the start bit at bit 4, the inverse of `diff_i` at bit 3, and the channel at bit 2. All other bits are 0.
- R4: For four- and eight-input variants, the command byte has the start bit at bit 6 and the inverse of `diff_i` at bit 5. The channel field begins at bit 2 and is 2 or 3 bits wide. All other bits are 0, and every bit after the command is 0.
- R5: Single-input variants have no command phase: 16 clock pulses are sent and MOSI stays 0.
- R6: For multi-input variants, with received bytes b0 (first) and b1, the result is the low RES_BITS bits of (b0·4 + b1/64) at 10 bits, or of (b0·16 + b1/16) at 12 bits.
- R7: For single-input 10-bit variants, the result is the low 10 bits of (b0·32 + b1/8). For single-input 12-bit variants, it is the low 12 bits of (b0·128 + b1/2).
- R8: For the single-input 13-bit variant, the result is b0[4:0] followed by b1, taken as two's complement and sign-extended to DATA_W bits.
- R9: In differential mode, the channel field carries `chan_i` unchanged. An even channel measures pair (c, c+1) and an odd channel measures pair (c, c-1). The only other difference from single-ended mode is the cleared single-ended bit.
- R10: A start request made while a transaction is in progress is ignored. No second transaction follows it, and the command already being sent is not changed.
- R11: `valid_o` is high for exactly one cycle, in the same cycle in which chip-select returns high, and `data_o` holds its value until the next strobe. A start request present during the strobe cycle is accepted, so chip-select is low again in the next cycle.
- R12: Bits of `chan_i` above log2 of the input count are ignored. The field sent is `chan_i` modulo the input count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Request one conversion (accepted only when idle) |
| chan_i | input | CH_W | Channel index |
| diff_i | input | 1 | 1 = differential pair, 0 = single-ended |
| sclk_o | output | 1 | Serial clock, idle low |
| cs_n_o | output | 1 | Active-low chip-select |
| mosi_o | output | 1 | Serial command data to the converter |
| miso_i | input | 1 | Serial reply data from the converter |
| data_o | output | DATA_W | Conversion result |
| valid_o | output | 1 | One-cycle strobe marking a new result |

## Verification
The completion strobe and the acceptance of a new request can fall in the same cycle. In that cycle the block is already idle, so a request held high across the strobe must start the next transaction at once. The bench provokes this by keeping the start request high through a whole conversion. It then judges that chip-select is high in exactly the strobe cycle and low in the cycle after it.

A start request pulsed in the middle of a transaction, with a different channel on the inputs, must produce neither a second chip-select period nor a changed command.

// File: rtl/sar_rd_pkg.sv
package sar_rd_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_LOW,
    ST_HIGH,
    ST_TAIL
  } rd_state_t;

  // Command bits sent ahead of the reply (0 for receive-only variants)
  function automatic int cmd_width(input int channels);
    return (channels > 1) ? 8 : 0;
  endfunction

  // Reply length in whole bytes, expressed in bits
  function automatic int reply_width(input int res_bits);
    return ((res_bits + 7) / 8) * 8;
  endfunction

  // Position of the result LSB inside the received reply word
  function automatic int result_lsb(input int channels, input int res_bits);
    return reply_width(res_bits) - res_bits - ((channels > 1) ? 0 : 3);
  endfunction

  function automatic bit result_signed(input int res_bits);
    return res_bits == 13;
  endfunction

endpackage

// File: rtl/sar_rd_tick.sv
module sar_rd_tick #(
  parameter int HALF_DIV = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic tick
);
  localparam int CNT_W = $clog2(HALF_DIV) + 1;

  logic [CNT_W-1:0] cnt;

  assign tick = run && (cnt == CNT_W'(HALF_DIV - 1));

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt <= '0;
    end else if (tick) begin
      cnt <= '0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/sar_rd_cmd.sv
module sar_rd_cmd #(
  parameter int CHANNELS = 8,
  parameter int CH_W     = 3
) (
  input  logic [CH_W-1:0] chan,
  input  logic            diff,
  output logic [7:0]      cmd
);
  // Start marker sits two places higher on the larger-count parts
  localparam int START_POS = (CHANNELS == 2) ? 4 : 6;

  logic [7:0] field;

  always_comb begin
    field = 8'((8'(chan) % 8'(CHANNELS)) << 2);
    cmd   = field;
    cmd[START_POS]     = 1'b1;
    cmd[START_POS - 1] = ~diff;
  end
endmodule

// File: rtl/sar_rd_extract.sv
module sar_rd_extract #(
  parameter int CHANNELS = 8,
  parameter int RES_BITS = 12,
  parameter int DATA_W   = 16,
  parameter int RX_W     = 16
) (
  input  logic [RX_W-1:0]   rx,
  output logic [DATA_W-1:0] value
);
  import sar_rd_pkg::*;

  localparam int LSB = result_lsb(CHANNELS, RES_BITS);

  logic [RES_BITS-1:0] raw;

  assign raw = RES_BITS'(rx >> LSB);

  generate
    if (result_signed(RES_BITS)) begin : g_sext
      assign value = {{(DATA_W - RES_BITS){raw[RES_BITS-1]}}, raw};
    end else begin : g_zext
      assign value = {{(DATA_W - RES_BITS){1'b0}}, raw};
    end
  endgenerate
endmodule

// File: rtl/sar_spi_reader.sv
module sar_spi_reader #(
  parameter int CHANNELS = 8,
  parameter int RES_BITS = 12,
  parameter int DATA_W   = 16,
  parameter int CH_W     = 3,
  parameter int HALF_DIV = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic [CH_W-1:0]   chan_i,
  input  logic              diff_i,
  output logic              sclk_o,
  output logic              cs_n_o,
  output logic              mosi_o,
  input  logic              miso_i,
  output logic [DATA_W-1:0] data_o,
  output logic              valid_o
);
  import sar_rd_pkg::*;

  localparam int CMD_W = cmd_width(CHANNELS);
  localparam int RX_W  = reply_width(RES_BITS);
  localparam int TOT   = CMD_W + RX_W;
  localparam int BIT_W = $clog2(TOT);
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(TOT - 1);

  rd_state_t         state;
  logic [TOT-1:0]    frame;
  logic [TOT-1:0]    tx_sh;
  logic [RX_W-1:0]   rx_sh;
  logic [BIT_W-1:0]  bit_idx;
  logic [DATA_W-1:0] value;
  logic              tick;

  generate
    if (CMD_W > 0) begin : g_cmd
      logic [7:0] cmd;
      sar_rd_cmd #(
        .CHANNELS (CHANNELS),
        .CH_W     (CH_W)
      ) u_cmd (
        .chan (chan_i),
        .diff (diff_i),
        .cmd  (cmd)
      );
      assign frame = {cmd, {RX_W{1'b0}}};
    end else begin : g_nocmd
      assign frame = '0;
    end
  endgenerate

  sar_rd_tick #(
    .HALF_DIV (HALF_DIV)
  ) u_tick (
    .clk  (clk),
    .rst  (rst),
    .run  (state != ST_IDLE),
    .tick (tick)
  );

  sar_rd_extract #(
    .CHANNELS (CHANNELS),
    .RES_BITS (RES_BITS),
    .DATA_W   (DATA_W),
    .RX_W     (RX_W)
  ) u_extract (
    .rx    (rx_sh),
    .value (value)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      cs_n_o  <= 1'b1;
      sclk_o  <= 1'b0;
      mosi_o  <= 1'b0;
      valid_o <= 1'b0;
      data_o  <= '0;
      tx_sh   <= '0;
      rx_sh   <= '0;
      bit_idx <= '0;
    end else begin
      valid_o <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (start_i) begin
            state   <= ST_LOW;
            cs_n_o  <= 1'b0;
            tx_sh   <= frame;
            mosi_o  <= frame[TOT-1];
            bit_idx <= '0;
          end
        end
        ST_LOW: begin
          if (tick) begin
            sclk_o <= 1'b1;
            rx_sh  <= {rx_sh[RX_W-2:0], miso_i};
            state  <= ST_HIGH;
          end
        end
        ST_HIGH: begin
          if (tick) begin
            sclk_o <= 1'b0;
            if (bit_idx == LAST_BIT) begin
              mosi_o <= 1'b0;
              state  <= ST_TAIL;
            end else begin
              bit_idx <= bit_idx + 1'b1;
              tx_sh   <= {tx_sh[TOT-2:0], 1'b0};
              mosi_o  <= tx_sh[TOT-2];
              state   <= ST_LOW;
            end
          end
        end
        ST_TAIL: begin
          if (tick) begin
            cs_n_o  <= 1'b1;
            valid_o <= 1'b1;
            data_o  <= value;
            state   <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sar_spi_reader_chk.sv
module sar_spi_reader_chk #(
  parameter int CHANNELS = 8,
  parameter int DATA_W   = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              start_i,
  input logic              sclk_o,
  input logic              cs_n_o,
  input logic              mosi_o,
  input logic [DATA_W-1:0] data_o,
  input logic              valid_o
);
  // R1: serial clock rests low whenever the device is deselected
  a_r1_idle_clock_low: assert property (@(posedge clk) disable iff (rst)
    cs_n_o |-> !sclk_o);

  // R2: the serial clock toggles only inside a chip-select window
  a_r2_clock_in_window: assert property (@(posedge clk) disable iff (rst)
    !$stable(sclk_o) |-> !cs_n_o);

  // R2: MOSI holds steady while the serial clock stays high
  a_r2_mosi_steady_high: assert property (@(posedge clk) disable iff (rst)
    (sclk_o && $past(sclk_o)) |-> $stable(mosi_o));

  // R10: a transaction only opens after a start request
  a_r10_open_needs_start: assert property (@(posedge clk) disable iff (rst)
    $fell(cs_n_o) |-> $past(start_i));

  // R11: one-cycle strobe, coincident with chip-select release
  a_r11_strobe_single: assert property (@(posedge clk) disable iff (rst)
    valid_o |=> !valid_o);

  a_r11_strobe_at_release: assert property (@(posedge clk) disable iff (rst)
    valid_o |-> $rose(cs_n_o));

  a_r11_result_held: assert property (@(posedge clk) disable iff (rst)
    !valid_o |-> $stable(data_o));

  generate
    if (CHANNELS == 1) begin : g_rx_only
      // R5: receive-only variants never drive MOSI high
      a_r5_mosi_quiet: assert property (@(posedge clk) disable iff (rst)
        !mosi_o);
    end
  endgenerate
endmodule

bind sar_spi_reader sar_spi_reader_chk #(
  .CHANNELS (CHANNELS),
  .DATA_W   (DATA_W)
) u_chk (
  .clk     (clk),
  .rst     (rst),
  .start_i (start_i),
  .sclk_o  (sclk_o),
  .cs_n_o  (cs_n_o),
  .mosi_o  (mosi_o),
  .data_o  (data_o),
  .valid_o (valid_o)
);

// File: tb/sar_spi_reader_test.sv
module sar_adc_model #(
  parameter int CMD_BITS = 8,
  parameter int RX_BITS  = 16
) (
  input  logic               clk,
  input  logic               cs_n,
  input  logic               sclk,
  input  logic               mosi,
  input  logic [RX_BITS-1:0] word,
  output logic               miso,
  output logic [7:0]         cmd_seen,
  output int                 rises,
  output int                 ones,
  output int                 low_cycles
);
  int falls;
  initial begin
    falls = 0; rises = 0; ones = 0; low_cycles = 0; cmd_seen = 8'd0;
  end
  always @(negedge cs_n) begin
    falls = 0; rises = 0; ones = 0; low_cycles = 0; cmd_seen = 8'd0;
  end
  always @(posedge sclk) if (!cs_n) begin
    if (rises < CMD_BITS) cmd_seen = {cmd_seen[6:0], mosi};
    if (mosi) ones++;
    rises++;
  end
  always @(negedge sclk) if (!cs_n) falls++;
  always @(posedge clk) if (!cs_n) low_cycles++;
  always @* begin
    int idx;
    idx = falls - CMD_BITS;
    miso = (idx >= 0 && idx < RX_BITS) ? word[RX_BITS - 1 - idx] : 1'b0;
  end
endmodule

module sar_spi_reader_test;
  localparam int H = 2;
  localparam int NI = 6;
  localparam int CHS [NI] = '{8, 2, 4, 1, 1, 1};
  localparam int RES [NI] = '{12, 10, 10, 10, 12, 13};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic [2:0] chan = 3'd0;
  logic diff = 1'b0;
  logic [15:0] reply = 16'd0;

  logic        sclk [NI];
  logic        csn  [NI];
  logic        mosi [NI];
  logic        miso [NI];
  logic [15:0] dat  [NI];
  logic        vld  [NI];
  logic [7:0]  cmd_seen [NI];
  int          rises [NI];
  int          ones  [NI];
  int          lowc  [NI];
  int          vcnt  [NI];
  int          base  [NI];
  logic [15:0] last  [NI];

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;

  always #4 clk = ~clk;

  for (genvar g = 0; g < NI; g++) begin : dut
    sar_spi_reader #(
      .CHANNELS (CHS[g]),
      .RES_BITS (RES[g]),
      .DATA_W   (16),
      .CH_W     (3),
      .HALF_DIV (H)
    ) uut (
      .clk     (clk),
      .rst     (rst),
      .start_i (start),
      .chan_i  (chan),
      .diff_i  (diff),
      .sclk_o  (sclk[g]),
      .cs_n_o  (csn[g]),
      .mosi_o  (mosi[g]),
      .miso_i  (miso[g]),
      .data_o  (dat[g]),
      .valid_o (vld[g])
    );
    sar_adc_model #(
      .CMD_BITS ((CHS[g] > 1) ? 8 : 0),
      .RX_BITS  (16)
    ) u_model (
      .clk        (clk),
      .cs_n       (csn[g]),
      .sclk       (sclk[g]),
      .mosi       (mosi[g]),
      .word       (reply),
      .miso       (miso[g]),
      .cmd_seen   (cmd_seen[g]),
      .rises      (rises[g]),
      .ones       (ones[g]),
      .low_cycles (lowc[g])
    );
  end

  initial for (int i = 0; i < NI; i++) begin vcnt[i] = 0; last[i] = 16'd0; end

  always @(posedge clk) begin
    for (int i = 0; i < NI; i++) begin
      if (vld[i]) begin
        last[i] <= dat[i];
        vcnt[i] <= vcnt[i] + 1;
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      n_bad++;
      $display("FAIL watchdog: run did not finish act=%0d exp=<150000", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_cmd(input int ch, input int c, input bit df);
    if (ch == 1) return 0;
    if (ch == 2) return 16 + (df ? 0 : 8) + (c % 2) * 4;
    return 64 + (df ? 0 : 32) + (c % ch) * 4;
  endfunction

  function automatic int popc(input int v);
    int n = 0;
    for (int b = 0; b < 8; b++) n += (v >> b) & 1;
    return n;
  endfunction

  function automatic int exp_data(input int ch, input int res, input int w);
    int b0 = w / 256;
    int b1 = w % 256;
    int v;
    if (ch > 1 && res == 10)      v = (b0 * 4 + b1 / 64) % 1024;
    else if (ch > 1)              v = (b0 * 16 + b1 / 16) % 4096;
    else if (res == 10)           v = (b0 * 32 + b1 / 8) % 1024;
    else if (res == 12)           v = (b0 * 128 + b1 / 2) % 4096;
    else begin
      v = (b0 % 32) * 256 + b1;
      if (v >= 4096) v = v + 65536 - 8192;
    end
    return v;
  endfunction

  function automatic string data_tag(input int i);
    return (CHS[i] > 1) ? "R6" : (RES[i] == 13) ? "R8" : "R7";
  endfunction

  function automatic string cmd_tag(input int i, input int c, input bit df);
    if (c >= CHS[i]) return "R12";
    if (df) return "R9";
    return (CHS[i] == 2) ? "R3" : "R4";
  endfunction

  task automatic snap();
    for (int i = 0; i < NI; i++) base[i] = vcnt[i];
  endtask

  task automatic wait_all();
    bit done = 1'b0;
    while (!done) begin
      @(negedge clk);
      done = 1'b1;
      for (int i = 0; i < NI; i++) if (vcnt[i] <= base[i]) done = 1'b0;
    end
  endtask

  task automatic run_one(input int c, input bit df, input logic [15:0] w);
    int n;
    reply = w;
    chan  = 3'(c);
    diff  = df;
    snap();
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    wait_all();
    repeat (2) @(negedge clk);
    for (int i = 0; i < NI; i++) begin
      n = (CHS[i] > 1) ? 24 : 16;
      check(data_tag(i), int'(last[i]), exp_data(CHS[i], RES[i], int'(w)));
      check((CHS[i] > 1) ? "R2" : "R5", rises[i], n);
      check("R2", lowc[i], (2 * n + 1) * H);
      if (CHS[i] > 1) begin
        check(cmd_tag(i, c, df), int'(cmd_seen[i]), exp_cmd(CHS[i], c, df));
        check("R4 data-phase MOSI", ones[i], popc(exp_cmd(CHS[i], c, df)));
      end else begin
        check("R5 MOSI quiet", ones[i], 0);
      end
    end
  endtask

  initial begin
    repeat (5) @(negedge clk);
    // R1: outputs held at rest during reset
    for (int i = 0; i < NI; i++) begin
      check("R1", {csn[i], sclk[i], mosi[i], vld[i]}, 4'b1000);
    end
    rst = 1'b0;
    repeat (4) @(negedge clk);
    for (int i = 0; i < NI; i++) begin
      check("R1", {csn[i], sclk[i], mosi[i], vld[i]}, 4'b1000);
    end

    // Sweep every channel code in both modes
    for (int c = 0; c < 8; c++) begin
      for (int df = 0; df < 2; df++) begin
        run_one(c, df[0], 16'(12345 + c * 4733 + df * 29123));
      end
    end
    // Boundary reply words, including signed extremes for R8
    run_one(3, 1'b0, 16'hFFFF);
    run_one(5, 1'b1, 16'h0000);
    run_one(0, 1'b0, 16'h1000);
    run_one(7, 1'b0, 16'h0FFF);
    run_one(2, 1'b1, 16'hE7FF);

    // R10: mid-transaction request with different inputs is ignored
    reply = 16'h5A3C;
    chan  = 3'd1;
    diff  = 1'b0;
    snap();
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    repeat (10) @(negedge clk);
    chan = 3'd6;
    diff = 1'b1;
    start = 1'b1;
    @(negedge clk) start = 1'b0;
    wait_all();
    repeat (150) @(negedge clk);
    for (int i = 0; i < NI; i++) begin
      check("R10 one result", vcnt[i] - base[i], 1);
      check("R10 idle after", int'(csn[i]), 1);
    end
    check("R10 command kept", int'(cmd_seen[0]), exp_cmd(8, 1, 1'b0));
    check("R10 command kept", int'(cmd_seen[1]), exp_cmd(2, 1, 1'b0));

    // R11: request held high across the strobe restarts at once
    reply = 16'h9C35;
    chan  = 3'd4;
    diff  = 1'b0;
    snap();
    @(negedge clk) start = 1'b1;
    while (!vld[0]) @(negedge clk);
    check("R11 release in strobe cycle", int'(csn[0]), 1);
    check("R11 first result", int'(dat[0]), exp_data(8, 12, 16'h9C35));
    @(negedge clk);
    check("R11 strobe width", int'(vld[0]), 0);
    check("R11 back-to-back start", int'(csn[0]), 0);
    start = 1'b0;
    repeat (250) @(negedge clk);
    check("R11 result held", int'(dat[0]), exp_data(8, 12, 16'h9C35));
    check("R11 second run", vcnt[0] - base[0], 2);
    check("R11 idle", int'(csn[0]), 1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule